// File: doc/BRIEF.md
# Preemptive Programmable-Priority Channel Arbiter

This block decides which of sixteen transfer channels the transfer engine serves next. Each channel raises a level request while it needs service. Software gives each channel a 4-bit priority level and a flag that allows the channel to be interrupted. These are held in one byte-wide control register per channel, which is reached through a plain write/read port. When the engine has no active channel, the arbiter grants the pending channel with the highest level.

When a channel is active, the arbiter takes a new decision only on an engine strobe. A `xferDone` strobe ends the active channel's service. A `xferBoundary` strobe marks a point inside the transfer where the channel may be interrupted. At a boundary, an interruptible active channel is suspended if a channel with a strictly higher level is waiting. The preempting channel runs in its place, and the suspended channel is granted again as soon as the preempting channel finishes. Only one suspension can be held at a time. The block produces only the grant, a one-cycle suspend pulse and a one-cycle resume pulse. Descriptors, addressing and data movement belong to other blocks.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, no channel is granted. Each channel's priority level equals its channel index, and its preemption flag is 0, so channel 15 reads 0x0F and channel 5 reads 0x05.
- R2: Control register byte layout: data[7] is the preemption enable, data[3:0] is the priority level, and data[6:4] are reserved. Writes to the reserved bits are ignored, and those bits read as zero. Reads are combinational on `cfgAddr`.
- R3: With no channel active, the highest-level pending request is granted. A larger value means higher priority. `grantValid`/`grantCh` update on the clock edge that samples the request.
- R4: When pending channels have equal levels, the lowest channel index wins.
- R5: While a channel is active and neither strobe is asserted, the grant does not change, whatever the requests do.
- R6: On `xferDone` with nothing suspended, the arbiter grants the best pending channel other than the finishing one on the same edge. If no other channel is pending, `grantValid` drops.
- R7: On `xferBoundary`, an active channel whose preemption enable is 1 is suspended only when a pending channel has a strictly higher level. In that case the new channel is granted, and `suspendPulse` is high for exactly one cycle with `suspendCh` naming the old channel.
- R8: An active channel whose preemption enable is 0 is never suspended.
- R9: While a suspension is held, the running preemptor cannot itself be preempted, even if its own enable is 1.
- R10: When the preemptor finishes, the suspended channel is granted ahead of any pending request. `resumePulse` is high for that one cycle.
- R11: A register write to the active channel takes effect at the next arbitration decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chReq | input | NUM_CH | Level service request per channel |
| xferBoundary | input | 1 | Engine strobe: preemption point of the active channel |
| xferDone | input | 1 | Engine strobe: active channel finished |
| cfgWrEn | input | 1 | Control register write enable |
| cfgAddr | input | ADDR_W | Control register select (channel index) |
| cfgWrData | input | 8 | Control register write data |
| cfgRdData | output | 8 | Control register read data |
| grantValid | output | 1 | A channel is active |
| grantCh | output | ADDR_W | Index of the active channel |
| suspendPulse | output | 1 | One-cycle pulse: a channel was suspended |
| suspendCh | output | ADDR_W | Channel suspended by the pulse |
| resumePulse | output | 1 | One-cycle pulse: suspended channel granted again |

## Verification
The grant, the suspend pulse and the resume pulse all come from one register stage. Each is due on the clock edge that samples the request or strobe that caused it, and the pulses last only that cycle. Register reads are combinational, so they are due in the same cycle as the address. The driver sets the inputs on the falling edge and queues the values expected after the next rising edge. The monitor compares one queued item a moment after each rising edge, so every check lands exactly one edge after its stimulus.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  // Control-to-datapath action strobes; at most one is set per cycle.
  typedef struct packed {
    logic loadWinner;
    logic doSuspend;
    logic doResume;
    logic goIdle;
  } ctrl_strobe_t;
endpackage

// File: rtl/dpa_regfile.sv
module dpa_regfile #(
  parameter int NUM_CH = 16,
  parameter int PRIO_W = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_CH-1:0][PRIO_W-1:0]  prioLvl,
  output logic [NUM_CH-1:0]              preemptEn
);
  localparam int RSV_W = DATA_W - 1 - PRIO_W;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chReg
    localparam logic [PRIO_W-1:0] RST_LVL = PRIO_W'(c);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioLvl[c]   <= RST_LVL;
        preemptEn[c] <= 1'b0;
      end else if (wrEn && (addr == ADDR_W'(c))) begin
        prioLvl[c]   <= wrData[PRIO_W-1:0];
        preemptEn[c] <= wrData[DATA_W-1];
      end
    end
  end

  assign rdData = {preemptEn[addr], {RSV_W{1'b0}}, prioLvl[addr]};

  // R2: reserved field never reads back non-zero
  always_comb begin
    a_r2_reserved_zero: assert (rdData[DATA_W-2:PRIO_W] == '0);
  end
endmodule

// File: rtl/dpa_datapath.sv
module dpa_datapath
  import dpa_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int PRIO_W = 4,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             req,
  input  logic [NUM_CH-1:0][PRIO_W-1:0] prioLvl,
  input  logic [NUM_CH-1:0]             preemptEn,
  input  ctrl_strobe_t                  strobe,
  output logic                          winnerValid,
  output logic                          winnerHigher,
  output logic                          actPreempt,
  output logic                          actValid,
  output logic [CH_W-1:0]               actCh,
  output logic                          suspValid,
  output logic                          suspPulse,
  output logic [CH_W-1:0]               suspPulseCh,
  output logic                          resumePulse
);
  logic [CH_W-1:0]   suspCh;
  logic [NUM_CH-1:0] busyMask;
  logic [NUM_CH-1:0] cand;
  logic [CH_W-1:0]   winCh;
  logic [PRIO_W-1:0] winLvl;

  // Channels already active or parked are not candidates.
  always_comb begin
    busyMask = '0;
    if (actValid)  busyMask[actCh]  = 1'b1;
    if (suspValid) busyMask[suspCh] = 1'b1;
    cand = req & ~busyMask;
  end

  // Descending scan with >= leaves the lowest index on equal levels.
  always_comb begin
    winnerValid = 1'b0;
    winCh       = '0;
    winLvl      = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i] && (!winnerValid || prioLvl[i] >= winLvl)) begin
        winnerValid = 1'b1;
        winCh       = CH_W'(i);
        winLvl      = prioLvl[i];
      end
    end
  end

  assign winnerHigher = winLvl > prioLvl[actCh];
  assign actPreempt   = preemptEn[actCh];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actValid    <= 1'b0;
      actCh       <= '0;
      suspValid   <= 1'b0;
      suspCh      <= '0;
      suspPulse   <= 1'b0;
      suspPulseCh <= '0;
      resumePulse <= 1'b0;
    end else begin
      suspPulse   <= 1'b0;
      resumePulse <= 1'b0;
      if (strobe.loadWinner) begin
        actValid <= 1'b1;
        actCh    <= winCh;
      end else if (strobe.doSuspend) begin
        suspValid   <= 1'b1;
        suspCh      <= actCh;
        actCh       <= winCh;
        suspPulse   <= 1'b1;
        suspPulseCh <= actCh;
      end else if (strobe.doResume) begin
        actCh       <= suspCh;
        suspValid   <= 1'b0;
        resumePulse <= 1'b1;
      end else if (strobe.goIdle) begin
        actValid <= 1'b0;
      end
    end
  end

  a_r6_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
  a_r7_suspend_guard: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doSuspend |-> (actPreempt && winnerHigher && !suspValid));
  a_r7_pulse_names_parked: assert property (@(posedge clk) disable iff (!rstN)
    suspPulse |-> (suspValid && suspCh == suspPulseCh));
  a_r9_parked_needs_runner: assert property (@(posedge clk) disable iff (!rstN)
    suspValid |-> actValid);
  a_r10_resume_needs_parked: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doResume |-> suspValid);
endmodule

// File: rtl/dpa_control.sv
module dpa_control
  import dpa_pkg::*;
(
  input  logic         actValid,
  input  logic         suspValid,
  input  logic         boundary,
  input  logic         done,
  input  logic         winnerValid,
  input  logic         winnerHigher,
  input  logic         actPreempt,
  output ctrl_strobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (!actValid) begin
      strobe.loadWinner = winnerValid;
    end else if (done) begin
      if (suspValid)        strobe.doResume   = 1'b1;
      else if (winnerValid) strobe.loadWinner = 1'b1;
      else                  strobe.goIdle     = 1'b1;
    end else if (boundary && actPreempt && !suspValid
                 && winnerValid && winnerHigher) begin
      strobe.doSuspend = 1'b1;
    end
  end

  // R8: a non-interruptible runner never yields at a boundary
  always_comb begin
    a_r8_no_suspend_locked: assert (!(strobe.doSuspend && !actPreempt));
  end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dpa_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int PRIO_W = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chReq,
  input  logic              xferBoundary,
  input  logic              xferDone,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              grantValid,
  output logic [ADDR_W-1:0] grantCh,
  output logic              suspendPulse,
  output logic [ADDR_W-1:0] suspendCh,
  output logic              resumePulse
);
  logic [NUM_CH-1:0][PRIO_W-1:0] prioLvl;
  logic [NUM_CH-1:0]             preemptEn;
  ctrl_strobe_t                  strobe;
  logic winnerValid, winnerHigher, actPreempt, suspValid;

  dpa_regfile #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .addr(cfgAddr), .wrData(cfgWrData),
    .rdData(cfgRdData), .prioLvl(prioLvl), .preemptEn(preemptEn));

  dpa_datapath #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .CH_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .req(chReq), .prioLvl(prioLvl), .preemptEn(preemptEn),
    .strobe(strobe), .winnerValid(winnerValid), .winnerHigher(winnerHigher),
    .actPreempt(actPreempt), .actValid(grantValid), .actCh(grantCh),
    .suspValid(suspValid), .suspPulse(suspendPulse), .suspPulseCh(suspendCh),
    .resumePulse(resumePulse));

  dpa_control ctrl_i (
    .actValid(grantValid), .suspValid(suspValid), .boundary(xferBoundary),
    .done(xferDone), .winnerValid(winnerValid), .winnerHigher(winnerHigher),
    .actPreempt(actPreempt), .strobe(strobe));

  a_r5_grant_stable: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !xferBoundary && !xferDone) |=> (grantValid && $stable(grantCh)));
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    suspendPulse |=> !suspendPulse);
  a_r10_resume_keeps_grant: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> grantValid);
endmodule

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  typedef struct {
    logic       vld;
    logic [3:0] ch;
    logic       sus;
    logic [3:0] susCh;
    logic       res;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] chReq = '0;
  logic xferBoundary = 1'b0, xferDone = 1'b0, cfgWrEn = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic grantValid, suspendPulse, resumePulse;
  logic [3:0] grantCh, suspendCh;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prio_arbiter dut_i (
    .clk(clk), .rstN(rstN), .chReq(chReq), .xferBoundary(xferBoundary),
    .xferDone(xferDone), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .grantValid(grantValid), .grantCh(grantCh),
    .suspendPulse(suspendPulse), .suspendCh(suspendCh), .resumePulse(resumePulse));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the result due after the edge.
  task automatic step(input logic [NCH-1:0] r, input logic bnd, input logic dn,
                      input logic eVld, input logic [3:0] eCh, input logic eSus,
                      input logic [3:0] eSusCh, input logic eRes, input string tag);
    exp_t e;
    @(negedge clk);
    chReq = r; xferBoundary = bnd; xferDone = dn; cfgWrEn = 1'b0;
    e.vld = eVld; e.ch = eCh; e.sus = eSus; e.susCh = eSusCh; e.res = eRes; e.tag = tag;
    expQ.push_back(e);
    @(posedge clk);
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    chReq = '0; xferBoundary = 1'b0; xferDone = 1'b0;
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfgAddr = a;
    #1;
    check(tag, {24'd0, cfgRdData}, {24'd0, exp});
  endtask

  // Monitor: compare one queued expectation just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check({e.tag, " grantValid"}, {31'd0, grantValid}, {31'd0, e.vld});
      if (e.vld) check({e.tag, " grantCh"}, {28'd0, grantCh}, {28'd0, e.ch});
      check({e.tag, " suspendPulse"}, {31'd0, suspendPulse}, {31'd0, e.sus});
      if (e.sus) check({e.tag, " suspendCh"}, {28'd0, suspendCh}, {28'd0, e.susCh});
      check({e.tag, " resumePulse"}, {31'd0, resumePulse}, {31'd0, e.res});
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check("R1 reset grantValid", {31'd0, grantValid}, 32'd0);
    regRead(4'd15, 8'h0F, "R1 reset reg15");
    regRead(4'd5, 8'h05, "R1 reset reg5");

    step(16'h0208, 0, 0, 1, 4'd9, 0, 0, 0, "R3 idle grant highest");
    step(16'h1000, 0, 0, 1, 4'd9, 0, 0, 0, "R5 hold without strobe");
    step(16'h1008, 0, 1, 1, 4'd12, 0, 0, 0, "R6 done next best");
    step(16'h0008, 0, 1, 1, 4'd3, 0, 0, 0, "R6 done again");
    step(16'h0000, 0, 1, 0, 4'd0, 0, 0, 0, "R6 done to idle");

    regWrite(4'd2, 8'hF7);
    regWrite(4'd4, 8'h07);
    regWrite(4'd9, 8'h89);
    regRead(4'd2, 8'h87, "R2 reserved ignored");
    regRead(4'd4, 8'h07, "R2 level field");

    step(16'h0014, 0, 0, 1, 4'd2, 0, 0, 0, "R4 tie lower index");
    step(16'h0000, 0, 1, 0, 4'd0, 0, 0, 0, "R6 idle");
    step(16'h0020, 0, 0, 1, 4'd5, 0, 0, 0, "R3 single request");
    step(16'h0200, 1, 0, 1, 4'd5, 0, 0, 0, "R8 locked channel kept");
    step(16'h0200, 0, 1, 1, 4'd9, 0, 0, 0, "R6 done to waiting");
    step(16'h0000, 0, 1, 0, 4'd0, 0, 0, 0, "R6 idle");

    step(16'h0004, 0, 0, 1, 4'd2, 0, 0, 0, "R3 grant ch2");
    step(16'h0200, 0, 0, 1, 4'd2, 0, 0, 0, "R5 no boundary no preempt");
    step(16'h0010, 1, 0, 1, 4'd2, 0, 0, 0, "R7 equal level no preempt");
    step(16'h0300, 1, 0, 1, 4'd9, 1, 4'd2, 0, "R7 preempt");
    step(16'h0100, 0, 0, 1, 4'd9, 0, 0, 0, "R7 pulse one cycle");
    step(16'h8000, 1, 0, 1, 4'd9, 0, 0, 0, "R9 one level only");
    step(16'h8100, 0, 1, 1, 4'd2, 0, 0, 1, "R10 resume parked");
    step(16'h8000, 0, 1, 1, 4'd15, 0, 0, 0, "R6 after resume");
    step(16'h0000, 0, 1, 0, 4'd0, 0, 0, 0, "R6 idle");

    step(16'h0040, 0, 0, 1, 4'd6, 0, 0, 0, "R3 grant ch6");
    regWrite(4'd6, 8'h81);
    step(16'h0008, 1, 0, 1, 4'd3, 1, 4'd6, 0, "R11 write takes effect");
    step(16'h0000, 0, 1, 1, 4'd6, 0, 0, 1, "R10 resume ch6");
    step(16'h0000, 0, 1, 0, 4'd0, 0, 0, 0, "R6 idle end");

    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule